// File: doc/BRIEF.md
# Software-Filled Unified TLB Entry Store

This block is the entry storage of a fully-associative unified translation buffer whose contents are managed entirely by software. Each entry holds a tag part (virtual page number, address-space identifier, valid, dirty) and a data part (physical page number, page size, protection, cacheable, write-through, shared, a 3-bit space attribute and a 1-bit timing attribute). Software fills entries in two ways. It can stage a new entry in three staging registers and issue a load command, which copies them into the entry chosen by a replacement counter. It can also read and write any entry directly through a memory-mapped port.

The replacement counter advances after every load and wraps at a software-set limit, or at the number of entries when the limit is zero. Software may also write the counter directly to pick the victim. The memory-mapped port offers three views of each entry: a tag view, a main data view and an auxiliary data view. The valid and dirty bits are one stored copy that both the tag view and the main data view reach. Only privileged, longword-sized data accesses are honoured; anything else raises an error and leaves every entry unchanged. A combinational query port reports whether a virtual page and address-space identifier hit a valid entry, and the dirty state of that entry.

Top module: `tlb_entry_array`

## Requirements
- R1: A load command copies the staging registers into the entry at the replacement counter, in the same clock edge. Staging select 0 is the high register, with VPN in bits 31:10 and ASID in bits 7:0. Select 1 is the low register, with PPN in 28:10, V in 8, SZ in 7:6, PR in 5:4, C in 3, D in 2, WT in 1 and SH in 0. Select 2 is the auxiliary register, with SA in 2:0 and TC in 3. Select 3 is ignored. A load uses the staging contents from before that edge.
- R2: After reset the replacement counter and the limit are 0, and every entry reads back with V cleared.
- R3: After a load the counter becomes (counter+1) modulo the bound, where the bound is the limit when the limit is non-zero and ENTRIES otherwise. A counter write in the same cycle as a load takes precedence over the increment. Without a load or a counter write, the counter holds its value.
- R4: If the counter has been written to a value at or above a non-zero limit, the next load still writes that entry, and the counter then returns to 0.
- R5: The memory-mapped address is {view[1:0], index}. In view 0 the word holds VPN in 31:10, D in 9, V in 8 and ASID in 7:0. View 1 uses the same layout as the low staging register. View 2 holds SA in 2:0 and TC in 3. V and D are a single copy per entry, so a write through view 0 or view 1 is visible through both views.
- R6: The access size code 2'b10 means longword. Any other size raises mm_err and changes no entry.
- R7: An access with mm_priv low raises mm_err and changes no entry.
- R8: An access with mm_ifetch high raises mm_err and changes no entry.
- R9: Reserved bits are ignored on write and read as 0. View 3 reads as 0, and writes to it change nothing.
- R10: q_hit is high when some entry has V set, has a VPN equal to q_vpn above the size mask, and has either SH set or an ASID equal to q_asid. The size mask ignores no low VPN bits for SZ 0, 2 bits for SZ 1, 6 bits for SZ 2 and 10 bits for SZ 3. If several entries match, the lowest index is reported on q_idx. q_dirty gives the D bit of that entry, and is 0 when there is no hit.
- R11: When a load and a memory-mapped write target the same entry in the same cycle, the load's values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_we | input | 1 | Staging register write strobe |
| stg_sel | input | 2 | Staging register select |
| stg_wdata | input | 32 | Staging write data |
| load_cmd | input | 1 | Load staged entry at the counter |
| rc_we | input | 1 | Replacement counter write |
| rc_wdata | input | IDX_W | Replacement counter value |
| lim_we | input | 1 | Limit write |
| lim_wdata | input | IDX_W | Limit value (0 = all entries) |
| rc_out | output | IDX_W | Current replacement counter |
| lim_out | output | IDX_W | Current limit |
| mm_req | input | 1 | Memory-mapped access request |
| mm_we | input | 1 | Access is a write |
| mm_size | input | 2 | Access size code |
| mm_priv | input | 1 | Access is privileged |
| mm_ifetch | input | 1 | Access is an instruction fetch |
| mm_addr | input | IDX_W+2 | {view, entry index} |
| mm_wdata | input | 32 | Write data |
| mm_rdata | output | 32 | Read data (combinational) |
| mm_err | output | 1 | Access rejected |
| q_vpn | input | 22 | Query virtual page number |
| q_asid | input | 8 | Query address-space identifier |
| q_hit | output | 1 | Query hit |
| q_dirty | output | 1 | Dirty bit of the hit entry |
| q_idx | output | IDX_W | Index of the hit entry |

## Verification
The bench builds the block with ENTRIES=16, so the index field is 4 bits wide. With that size, a run of loads goes past the natural wrap, and the counter is seen returning to 0 both at the entry count and at a small non-zero limit. The smaller array also lets the bench recompute, every cycle, the query result over all entries, including duplicate matches and every page size. Error cases, dual-view valid/dirty updates and the load-versus-write collision are all placed on entries whose contents are known.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 22;
  localparam int ASID_W = 8;
  localparam int PPN_W  = 19;
  localparam logic [1:0] SIZE_LONG = 2'b10;

  typedef enum logic [1:0] {
    VIEW_TAG  = 2'd0,
    VIEW_DAT1 = 2'd1,
    VIEW_DAT2 = 2'd2,
    VIEW_NONE = 2'd3
  } view_e;

  typedef enum logic [1:0] {
    STG_HI  = 2'd0,
    STG_LO  = 2'd1,
    STG_AUX = 2'd2,
    STG_NIL = 2'd3
  } stg_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              v;
    logic              d;
  } tlb_tag_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       sz;
    logic [1:0]       pr;
    logic             c;
    logic             wt;
    logic             sh;
    logic [2:0]       sa;
    logic             tc;
  } tlb_dat_t;

  function automatic logic [31:0] tag_word(tlb_tag_t t);
    return {t.vpn, t.d, t.v, t.asid};
  endfunction

  function automatic logic [31:0] dat1_word(tlb_tag_t t, tlb_dat_t d);
    return {3'b000, d.ppn, 1'b0, t.v, d.sz, d.pr, d.c, t.d, d.wt, d.sh};
  endfunction

  function automatic logic [31:0] dat2_word(tlb_dat_t d);
    return {28'd0, d.tc, d.sa};
  endfunction

  // Next replacement counter value; bound is lim, or n when lim is zero.
  function automatic int unsigned next_rc(int unsigned rc, int unsigned lim,
                                          int unsigned n);
    int unsigned bound;
    bound = (lim == 0) ? n : lim;
    return ((rc + 1) >= bound) ? 0 : rc + 1;
  endfunction

  // VPN compare mask for a page-size code.
  function automatic logic [VPN_W-1:0] vpn_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return {VPN_W{1'b1}};
      2'd1:    return {{(VPN_W-2){1'b1}}, 2'b00};
      2'd2:    return {{(VPN_W-6){1'b1}}, 6'b000000};
      default: return {{(VPN_W-10){1'b1}}, 10'b0000000000};
    endcase
  endfunction

  function automatic logic entry_match(tlb_tag_t t, tlb_dat_t d,
                                       logic [VPN_W-1:0] qv,
                                       logic [ASID_W-1:0] qa);
    logic [VPN_W-1:0] m;
    m = vpn_mask(d.sz);
    return t.v && ((t.vpn & m) == (qv & m)) && (d.sh || (t.asid == qa));
  endfunction
endpackage

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             rc_we,
  input  logic [IDX_W-1:0] rc_wdata,
  input  logic             lim_we,
  input  logic [IDX_W-1:0] lim_wdata,
  output logic [IDX_W-1:0] rc_q,
  output logic [IDX_W-1:0] lim_q
);
  import tlb_pkg::*;

  logic [IDX_W-1:0] rc_inc;

  always_comb begin
    rc_inc = IDX_W'(next_rc(int'(rc_q), int'(lim_q), ENTRIES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc_q  <= '0;
      lim_q <= '0;
    end else begin
      if (rc_we)     rc_q <= rc_wdata;
      else if (load) rc_q <= rc_inc;
      if (lim_we)    lim_q <= lim_wdata;
    end
  end

  // R3: counter holds when neither loaded nor written
  p_rc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rc_we) |=> $stable(rc_q));

  // R4: counter at or above a non-zero limit returns to zero after a load
  p_rc_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !rc_we && lim_q != '0 && rc_q >= lim_q) |=> (rc_q == '0));

  // R3: a counter write takes precedence over the increment
  p_rc_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rc_we |=> (rc_q == $past(rc_wdata)));
endmodule

// File: rtl/tlb_mm_decode.sv
module tlb_mm_decode #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mm_req,
  input  logic               mm_we,
  input  logic [1:0]         mm_size,
  input  logic               mm_priv,
  input  logic               mm_ifetch,
  input  logic [IDX_W+1:0]   mm_addr,
  output tlb_pkg::view_e     view,
  output logic [IDX_W-1:0]   idx,
  output logic               grant_wr,
  output logic               grant_rd,
  output logic               err
);
  import tlb_pkg::*;

  logic bad_size, bad_mode, bad_idx;

  always_comb begin
    view     = view_e'(mm_addr[IDX_W+1:IDX_W]);
    idx      = mm_addr[IDX_W-1:0];
    bad_size = (mm_size != SIZE_LONG);
    bad_mode = !mm_priv || mm_ifetch;
    bad_idx  = (int'(idx) >= ENTRIES);
    err      = mm_req && (bad_size || bad_mode || bad_idx);
    grant_wr = mm_req && mm_we && !err;
    grant_rd = mm_req && !mm_we && !err;
  end

  // R7: a user-mode request is always refused
  p_priv_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && !mm_priv) |-> (err && !grant_wr));

  // R8: instruction fetches are always refused
  p_ifetch_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && mm_ifetch) |-> (err && !grant_rd));
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tlb_pkg::tlb_tag_t       tags [ENTRIES],
  input  tlb_pkg::tlb_dat_t       dats [ENTRIES],
  input  logic [tlb_pkg::VPN_W-1:0]  q_vpn,
  input  logic [tlb_pkg::ASID_W-1:0] q_asid,
  output logic                    hit,
  output logic                    dirty,
  output logic [IDX_W-1:0]        hit_idx
);
  import tlb_pkg::*;

  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = entry_match(tags[g], dats[g], q_vpn, q_asid);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    dirty = hit && tags[hit_idx].d;
  end

  // R10: a reported hit names a valid entry that really matches
  p_hit_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (tags[hit_idx].v && match_vec[hit_idx]));

  // R10: no hit is reported when nothing matches
  p_no_false_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec == '0) |-> (!hit && !dirty));
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stg_we,
  input  logic [1:0]         stg_sel,
  input  logic [31:0]        stg_wdata,
  input  logic               load_cmd,
  input  logic               rc_we,
  input  logic [IDX_W-1:0]   rc_wdata,
  input  logic               lim_we,
  input  logic [IDX_W-1:0]   lim_wdata,
  output logic [IDX_W-1:0]   rc_out,
  output logic [IDX_W-1:0]   lim_out,
  input  logic               mm_req,
  input  logic               mm_we,
  input  logic [1:0]         mm_size,
  input  logic               mm_priv,
  input  logic               mm_ifetch,
  input  logic [IDX_W+1:0]   mm_addr,
  input  logic [31:0]        mm_wdata,
  output logic [31:0]        mm_rdata,
  output logic               mm_err,
  input  logic [21:0]        q_vpn,
  input  logic [7:0]         q_asid,
  output logic               q_hit,
  output logic               q_dirty,
  output logic [IDX_W-1:0]   q_idx
);
  import tlb_pkg::*;

  tlb_tag_t tag_q [ENTRIES];
  tlb_dat_t dat_q [ENTRIES];
  tlb_tag_t stg_hi_q;
  tlb_dat_t stg_lo_q;
  logic     stg_lo_v, stg_lo_d;
  logic [3:0] stg_aux_q;

  view_e            mm_view;
  logic [IDX_W-1:0] mm_idx;
  logic             grant_wr, grant_rd;
  logic [ENTRIES-1:0] mm_wen;
  logic [ENTRIES-1:0] ld_wen;
  logic [IDX_W-1:0] rc_q;

  tlb_repl_ctr #(.ENTRIES(ENTRIES)) u_rc (
    .clk(clk), .rst_n(rst_n), .load(load_cmd),
    .rc_we(rc_we), .rc_wdata(rc_wdata),
    .lim_we(lim_we), .lim_wdata(lim_wdata),
    .rc_q(rc_q), .lim_q(lim_out)
  );
  assign rc_out = rc_q;

  tlb_mm_decode #(.ENTRIES(ENTRIES)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .mm_req(mm_req), .mm_we(mm_we), .mm_size(mm_size),
    .mm_priv(mm_priv), .mm_ifetch(mm_ifetch), .mm_addr(mm_addr),
    .view(mm_view), .idx(mm_idx),
    .grant_wr(grant_wr), .grant_rd(grant_rd), .err(mm_err)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .clk(clk), .rst_n(rst_n), .tags(tag_q), .dats(dat_q),
    .q_vpn(q_vpn), .q_asid(q_asid),
    .hit(q_hit), .dirty(q_dirty), .hit_idx(q_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_wen
    assign mm_wen[g] = grant_wr && (mm_idx == IDX_W'(g)) && (mm_view != VIEW_NONE);
    assign ld_wen[g] = load_cmd && (rc_q == IDX_W'(g));
  end

  // Staging registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_hi_q  <= '0;
      stg_lo_q  <= '0;
      stg_lo_v  <= 1'b0;
      stg_lo_d  <= 1'b0;
      stg_aux_q <= '0;
    end else if (stg_we) begin
      case (stg_e'(stg_sel))
        STG_HI: begin
          stg_hi_q.vpn  <= stg_wdata[31:10];
          stg_hi_q.asid <= stg_wdata[7:0];
        end
        STG_LO: begin
          stg_lo_q.ppn <= stg_wdata[28:10];
          stg_lo_v     <= stg_wdata[8];
          stg_lo_q.sz  <= stg_wdata[7:6];
          stg_lo_q.pr  <= stg_wdata[5:4];
          stg_lo_q.c   <= stg_wdata[3];
          stg_lo_d     <= stg_wdata[2];
          stg_lo_q.wt  <= stg_wdata[1];
          stg_lo_q.sh  <= stg_wdata[0];
        end
        STG_AUX: stg_aux_q <= stg_wdata[3:0];
        default: ;
      endcase
    end
  end

  // Entry storage: port write first, load last so a load wins a collision.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        dat_q[g] <= '0;
      end else begin
        if (mm_wen[g]) begin
          case (mm_view)
            VIEW_TAG: begin
              tag_q[g].vpn  <= mm_wdata[31:10];
              tag_q[g].d    <= mm_wdata[9];
              tag_q[g].v    <= mm_wdata[8];
              tag_q[g].asid <= mm_wdata[7:0];
            end
            VIEW_DAT1: begin
              dat_q[g].ppn <= mm_wdata[28:10];
              tag_q[g].v   <= mm_wdata[8];
              dat_q[g].sz  <= mm_wdata[7:6];
              dat_q[g].pr  <= mm_wdata[5:4];
              dat_q[g].c   <= mm_wdata[3];
              tag_q[g].d   <= mm_wdata[2];
              dat_q[g].wt  <= mm_wdata[1];
              dat_q[g].sh  <= mm_wdata[0];
            end
            VIEW_DAT2: begin
              dat_q[g].sa <= mm_wdata[2:0];
              dat_q[g].tc <= mm_wdata[3];
            end
            default: ;
          endcase
        end
        if (ld_wen[g]) begin
          tag_q[g].vpn  <= stg_hi_q.vpn;
          tag_q[g].asid <= stg_hi_q.asid;
          tag_q[g].v    <= stg_lo_v;
          tag_q[g].d    <= stg_lo_d;
          dat_q[g].ppn  <= stg_lo_q.ppn;
          dat_q[g].sz   <= stg_lo_q.sz;
          dat_q[g].pr   <= stg_lo_q.pr;
          dat_q[g].c    <= stg_lo_q.c;
          dat_q[g].wt   <= stg_lo_q.wt;
          dat_q[g].sh   <= stg_lo_q.sh;
          dat_q[g].sa   <= stg_aux_q[2:0];
          dat_q[g].tc   <= stg_aux_q[3];
        end
      end
    end
  end

  // Read mux
  always_comb begin
    mm_rdata = '0;
    if (grant_rd) begin
      case (mm_view)
        VIEW_TAG:  mm_rdata = tag_word(tag_q[mm_idx]);
        VIEW_DAT1: mm_rdata = dat1_word(tag_q[mm_idx], dat_q[mm_idx]);
        VIEW_DAT2: mm_rdata = dat2_word(dat_q[mm_idx]);
        default:   mm_rdata = '0;
      endcase
    end
  end

  // R6: a refused access enables no entry write
  p_err_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mm_err |-> (mm_wen == '0));

  // R1: a load lands the staged tag in the entry the counter pointed at
  p_load_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_cmd |=> (tag_q[$past(rc_q)].vpn == $past(stg_hi_q.vpn)
                  && tag_q[$past(rc_q)].v == $past(stg_lo_v)));

  // R1: at most one entry is loaded per cycle
  p_one_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_wen));

  // R9: view 3 reads back zero
  p_view3_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_rd && mm_view == VIEW_NONE) |-> (mm_rdata == 32'd0));

  // R5: tag view and main data view agree on V and D
  p_vd_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_rd && mm_view == VIEW_TAG) |->
      (mm_rdata[9:8] == {dat1_word(tag_q[mm_idx], dat_q[mm_idx])[2],
                         dat1_word(tag_q[mm_idx], dat_q[mm_idx])[8]}));
endmodule

// File: tb/sim_tlb_entry_array.sv
module sim_tlb_entry_array;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stg_we = 0; logic [1:0] stg_sel = 0; logic [31:0] stg_wdata = 0;
  logic load_cmd = 0;
  logic rc_we = 0; logic [IW-1:0] rc_wdata = 0;
  logic lim_we = 0; logic [IW-1:0] lim_wdata = 0;
  logic [IW-1:0] rc_out, lim_out;
  logic mm_req = 0, mm_we = 0, mm_priv = 1, mm_ifetch = 0;
  logic [1:0] mm_size = 2'b10;
  logic [IW+1:0] mm_addr = 0;
  logic [31:0] mm_wdata = 0, mm_rdata;
  logic mm_err;
  logic [21:0] q_vpn = 0; logic [7:0] q_asid = 0;
  logic q_hit, q_dirty; logic [IW-1:0] q_idx;

  tlb_entry_array #(.ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_sel(stg_sel),
    .stg_wdata(stg_wdata), .load_cmd(load_cmd), .rc_we(rc_we),
    .rc_wdata(rc_wdata), .lim_we(lim_we), .lim_wdata(lim_wdata),
    .rc_out(rc_out), .lim_out(lim_out), .mm_req(mm_req), .mm_we(mm_we),
    .mm_size(mm_size), .mm_priv(mm_priv), .mm_ifetch(mm_ifetch),
    .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .mm_err(mm_err), .q_vpn(q_vpn), .q_asid(q_asid), .q_hit(q_hit),
    .q_dirty(q_dirty), .q_idx(q_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_vpn[N], m_asid[N], m_v[N], m_d[N], m_ppn[N], m_sz[N], m_pr[N];
  int m_c[N], m_wt[N], m_sh[N], m_sa[N], m_tc[N];
  int s_hi = 0, s_lo = 0, s_aux = 0, m_rc = 0, m_lim = 0;
  int checks = 0, failures = 0;
  string tag = "R2";
  bit done = 0;

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint view_word(int vw, int i);
    case (vw)
      0: return (longint'(m_vpn[i]) << 10) + m_d[i]*512 + m_v[i]*256 + m_asid[i];
      1: return (longint'(m_ppn[i]) << 10) + m_v[i]*256 + m_sz[i]*64
                + m_pr[i]*16 + m_c[i]*8 + m_d[i]*4 + m_wt[i]*2 + m_sh[i];
      2: return m_tc[i]*8 + m_sa[i];
      default: return 0;
    endcase
  endfunction

  function automatic int find_hit();
    int low;
    for (int i = 0; i < N; i++) begin
      low = (m_sz[i] == 0) ? 0 : (m_sz[i] == 1) ? 2 : (m_sz[i] == 2) ? 6 : 10;
      if (m_v[i] == 1 && (m_vpn[i] >> low) == (int'(q_vpn) >> low)
          && (m_sh[i] == 1 || m_asid[i] == int'(q_asid)))
        return i;
    end
    return -1;
  endfunction

  function automatic bit exp_err();
    return mm_req && (mm_size != 2'b10 || !mm_priv || mm_ifetch);
  endfunction

  task automatic apply_tag(int i, int w);
    m_vpn[i] = (w >> 10) & 32'h3FFFFF; m_d[i] = (w >> 9) & 1;
    m_v[i] = (w >> 8) & 1; m_asid[i] = w & 255;
  endtask

  task automatic apply_lo(int i, int w);
    m_ppn[i] = (w >> 10) & 32'h7FFFF; m_v[i] = (w >> 8) & 1;
    m_sz[i] = (w >> 6) & 3; m_pr[i] = (w >> 4) & 3; m_c[i] = (w >> 3) & 1;
    m_d[i] = (w >> 2) & 1; m_wt[i] = (w >> 1) & 1; m_sh[i] = w & 1;
  endtask

  // one cycle: compare combinational outputs, then advance the model
  task automatic cyc();
    int h, vw, ix, bound, e;
    #1;
    chk(rc_out == IW'(m_rc), "R3 rc_out", rc_out, m_rc);
    chk(lim_out == IW'(m_lim), "R3 lim_out", lim_out, m_lim);
    chk(mm_err == exp_err(), "R6 mm_err", mm_err, exp_err());
    vw = int'(mm_addr[IW+1:IW]); ix = int'(mm_addr[IW-1:0]);
    if (mm_req && !mm_we && !exp_err())
      chk(mm_rdata == 32'(view_word(vw, ix)), "R5 mm_rdata", mm_rdata, view_word(vw, ix));
    h = find_hit();
    chk(q_hit == (h >= 0), "R10 q_hit", q_hit, h >= 0);
    if (h >= 0) begin
      chk(q_idx == IW'(h), "R10 q_idx", q_idx, h);
      chk(q_dirty == m_d[h][0], "R10 q_dirty", q_dirty, m_d[h]);
    end else chk(q_dirty == 0, "R10 q_dirty", q_dirty, 0);
    @(posedge clk);
    if (mm_req && mm_we && !exp_err()) begin
      if (vw == 0) apply_tag(ix, int'(mm_wdata));
      else if (vw == 1) apply_lo(ix, int'(mm_wdata));
      else if (vw == 2) begin
        m_sa[ix] = int'(mm_wdata) & 7; m_tc[ix] = (int'(mm_wdata) >> 3) & 1;
      end
    end
    if (load_cmd) begin
      e = m_rc;
      m_vpn[e] = (s_hi >> 10) & 32'h3FFFFF; m_asid[e] = s_hi & 255;
      apply_lo(e, s_lo);
      m_sa[e] = s_aux & 7; m_tc[e] = (s_aux >> 3) & 1;
    end
    if (stg_we) begin
      if (stg_sel == 0) s_hi = int'(stg_wdata);
      else if (stg_sel == 1) s_lo = int'(stg_wdata);
      else if (stg_sel == 2) s_aux = int'(stg_wdata);
    end
    bound = (m_lim == 0) ? N : m_lim;
    if (rc_we) m_rc = int'(rc_wdata);
    else if (load_cmd) m_rc = (m_rc + 1 >= bound) ? 0 : m_rc + 1;
    if (lim_we) m_lim = int'(lim_wdata);
    @(negedge clk);
    stg_we = 0; load_cmd = 0; rc_we = 0; lim_we = 0;
    mm_req = 0; mm_we = 0; mm_size = 2'b10; mm_priv = 1; mm_ifetch = 0;
  endtask

  task automatic stage(int sel, logic [31:0] w);
    stg_we = 1; stg_sel = 2'(sel); stg_wdata = w; cyc();
  endtask
  task automatic do_load(); load_cmd = 1; cyc(); endtask
  task automatic mm_rd(int vw, int ix);
    mm_req = 1; mm_we = 0; mm_addr = {2'(vw), IW'(ix)}; cyc();
  endtask
  task automatic mm_wr(int vw, int ix, logic [31:0] w);
    mm_req = 1; mm_we = 1; mm_addr = {2'(vw), IW'(ix)}; mm_wdata = w; cyc();
  endtask
  task automatic read_all(int ix);
    for (int v = 0; v < 4; v++) mm_rd(v, ix);
  endtask
  task automatic fill(int ix, logic [31:0] hi, logic [31:0] lo, logic [31:0] aux);
    stage(0, hi); stage(1, lo); stage(2, aux);
    rc_we = 1; rc_wdata = IW'(ix); cyc();
    do_load();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = 0; m_asid[i] = 0; m_v[i] = 0; m_d[i] = 0; m_ppn[i] = 0;
      m_sz[i] = 0; m_pr[i] = 0; m_c[i] = 0; m_wt[i] = 0; m_sh[i] = 0;
      m_sa[i] = 0; m_tc[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: reset state
    tag = "R2";
    for (int i = 0; i < N; i += 5) read_all(i);
    // R1: staged loads at counter
    tag = "R1";
    stage(0, 32'hABCDE455); stage(1, 32'h1234567D); stage(2, 32'h0000000B);
    do_load(); read_all(0);
    stage(0, 32'h00000C01); stage(1, 32'h00000100); do_load(); read_all(1);
    stage(3, 32'hFFFFFFFF); do_load(); read_all(2);
    // R3: wrap at entry count, counter write priority
    tag = "R3";
    for (int k = 0; k < 18; k++) begin stage(0, 32'(k) << 12); do_load(); end
    lim_we = 1; lim_wdata = 5; cyc();
    rc_we = 1; rc_wdata = 3; cyc();
    do_load(); do_load(); do_load();
    load_cmd = 1; rc_we = 1; rc_wdata = 9; cyc();
    // R4: counter above limit
    tag = "R4";
    rc_we = 1; rc_wdata = 12; cyc();
    stage(0, 32'h77777000); do_load(); read_all(12);
    lim_we = 1; lim_wdata = 0; cyc();
    // R5: shared V/D
    tag = "R5";
    mm_wr(0, 7, 32'h12345355); mm_rd(1, 7);
    mm_wr(1, 7, 32'h00054108); mm_rd(0, 7); mm_rd(1, 7);
    mm_wr(2, 7, 32'hFFFFFFF5); mm_rd(2, 7);
    // R6/R7/R8: refused accesses
    tag = "R6";
    mm_size = 2'b01; mm_wr(0, 7, 32'hFFFFFFFF); mm_size = 2'b00; mm_rd(0, 7);
    read_all(7);
    tag = "R7";
    mm_priv = 0; mm_wr(1, 7, 32'h0); mm_priv = 0; mm_rd(1, 7); read_all(7);
    tag = "R8";
    mm_ifetch = 1; mm_wr(0, 7, 32'h0); mm_ifetch = 1; mm_rd(0, 7); read_all(7);
    // R9: reserved bits and view 3
    tag = "R9";
    mm_wr(1, 9, 32'hFFFFFFFF); mm_rd(1, 9); mm_wr(3, 9, 32'hFFFFFFFF);
    read_all(9); mm_wr(2, 9, 32'hFFFFFFF0); mm_rd(2, 9);
    // R10: lookup
    tag = "R10";
    fill(4, 32'h00400011, 32'h00000100, 0);
    fill(5, 32'h00400022, 32'h00000105, 0);
    fill(6, 32'h00800033, 32'h000001C4, 0);
    q_vpn = 22'h001000 >> 0; q_asid = 8'h11; cyc();
    q_vpn = 22'h001; q_asid = 8'h11; cyc();
    q_vpn = 22'h001; q_asid = 8'h22; cyc();
    q_vpn = 22'h001; q_asid = 8'h99; cyc();
    q_vpn = 22'h002; q_asid = 8'h33; cyc();
    q_vpn = 22'h2FF; q_asid = 8'h33; cyc();
    q_vpn = 22'h5FF; q_asid = 8'h33; cyc();
    q_vpn = 22'h001; q_asid = 8'h11; cyc();
    mm_wr(0, 4, 32'h0); cyc();
    q_vpn = 22'h3FFFFF; cyc();
    // R11: load and port write collide
    tag = "R11";
    stage(0, 32'h13579022); stage(1, 32'h0004A3F6);
    rc_we = 1; rc_wdata = 10; cyc();
    load_cmd = 1; mm_req = 1; mm_we = 1; mm_addr = {2'd1, IW'(10)};
    mm_wdata = 32'h1FFFFC00; cyc();
    read_all(10);
    load_cmd = 1; mm_req = 1; mm_we = 1; mm_addr = {2'd1, IW'(2)};
    mm_wdata = 32'h00001104; cyc();
    read_all(11); read_all(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule